// File: doc/BRIEF.md
# USB Host Token Command Controller

This block keeps the pending token command of a small USB host and runs the issue sequence for each token. Software writes one command byte. That byte carries a data-toggle bit, a token kind and an endpoint number. If the write is allowed, the block raises a request to a downstream packet engine.

The request stays up until the engine returns a done pulse. At that point the block clears the token kind by itself, sets a sticky completion flag and starts a guard interval. The next token cannot be requested until that interval has run out. The interval is counted in USB bit-clock enable pulses.

The stored toggle bit has two uses. On transmit it selects the data PID. On receive it is compared with the toggle the receiver reports, and a mismatch raises an error.

Top module: `usb_tok_ctrl`

## Requirements
- R1: After `rst_n` is asserted, the command byte reads 0x00, `tok_req` is 0, and `cmp_flag` and `cmp_irq` are 0.
- R2: The command byte layout is: bit 7 = toggle (0 = DATA0, 1 = DATA1), bits 6..4 = token kind, bits 3..0 = endpoint. `cmd_rd` returns the stored byte in this layout.
- R3: Token kind codes are 001 SETUP, 010 IN, 011 OUT and 100 SOF. A write carrying 000 or any of 101..111 leaves the kind at 000. `tok_kind` shows the kind while `tok_req` is 1 and shows 000 otherwise.
- R4: A write changes the token kind only when `soft_rst` is 0, `host_mode` is 1 and `link_up` is 1. In any other case the kind stays 000 and no request starts.
- R5: `tok_req` is 1 while the kind is nonzero and the guard interval has expired. A cycle with both `tok_req` and `eng_done` high completes the token, and the kind reads 000 from the next cycle.
- R6: A completion sets `cmp_flag`, which then stays set. `irq_clr` clears it. When a completion and `irq_clr` fall in the same cycle, the flag ends up set. `cmp_irq` equals `cmp_flag` AND `irq_en`.
- R7: While the kind is SOF (100), `tok_ep` reads 0 and `tok_tgl` reads 0, whatever is stored. For any other kind these outputs show the stored endpoint and toggle.
- R8: `rx_tgl_err` is 1 exactly when `rx_valid` is 1 and `rx_tgl` differs from the stored toggle.
- R9: After a completion, `tok_req` stays 0 until three `bit_en` pulses have been seen at clock edges after the completion edge. A `bit_en` in the completion cycle itself is not counted.
- R10: While the kind is nonzero, every write is ignored. The toggle, endpoint and kind do not change.
- R11: While `soft_rst` is 1, all three fields are cleared to zero and writes are ignored.
- R12: An `eng_done` pulse while `tok_req` is 0 has no effect on the fields, the flag or the guard interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Controller soft reset, active high |
| host_mode | input | 1 | Controller is in host mode |
| link_up | input | 1 | A device is connected |
| bit_en | input | 1 | One-cycle USB bit-clock enable |
| wr_en | input | 1 | Command byte write strobe |
| wr_data | input | 8 | Command byte write data |
| irq_clr | input | 1 | Write-one-to-clear strobe for the completion flag |
| irq_en | input | 1 | Completion interrupt enable |
| eng_done | input | 1 | Packet engine finished the token |
| rx_valid | input | 1 | A received data toggle is presented |
| rx_tgl | input | 1 | Received data toggle |
| tok_req | output | 1 | Token request to the packet engine |
| tok_kind | output | 3 | Token kind being requested |
| tok_ep | output | 4 | Endpoint for the token (0 for SOF) |
| tok_tgl | output | 1 | Toggle for the data PID (0 for SOF) |
| rx_tgl_err | output | 1 | Received toggle mismatch |
| cmd_rd | output | 8 | Stored command byte |
| cmp_flag | output | 1 | Sticky completion flag |
| cmp_irq | output | 1 | Completion interrupt |

## Verification
Two functions can land on the same edge. The first is the engine's done pulse, which sets the completion flag. The second is software's clear strobe, which removes it. The bench provokes the collision directly: it holds `irq_clr` high through the cycle in which `eng_done` completes a token. It then expects the flag to read 1 on the following cycle, and expects a separate clear-only cycle to drop the flag to 0. Random traffic also drives both strobes freely. A behavioural model then judges every cycle, including the cycles where a write arrives together with a completion and must be ignored.

// File: rtl/usb_tok_pkg.sv
package usb_tok_pkg;
    localparam int EP_W  = 4;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        TK_NONE  = 3'd0,
        TK_SETUP = 3'd1,
        TK_IN    = 3'd2,
        TK_OUT   = 3'd3,
        TK_SOF   = 3'd4
    } tok_kind_e;

    // Packed so that the field order matches the software-visible byte
    typedef struct packed {
        logic             tgl;
        tok_kind_e        sel;
        logic [EP_W-1:0]  ep;
    } tok_cmd_t;

    function automatic logic kind_ok(input logic [SEL_W-1:0] v);
        return (v != 3'd0) && (v <= 3'd4);
    endfunction
endpackage

// File: rtl/usb_tok_holdoff.sv
module usb_tok_holdoff #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic bit_en,
    output logic ready
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CW'(HOLD);
        else if (bit_en && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);

    AST_GUARD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ready); // R9
endmodule

// File: rtl/usb_tok_irq.sv
module usb_tok_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic irq
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
    assign irq  = flag_q & en;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag); // R6
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag); // R6
endmodule

// File: rtl/usb_tok_ctrl.sv
module usb_tok_ctrl
    import usb_tok_pkg::*;
#(
    parameter int HOLD_BITS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        host_mode,
    input  logic        link_up,
    input  logic        bit_en,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        irq_clr,
    input  logic        irq_en,
    input  logic        eng_done,
    input  logic        rx_valid,
    input  logic        rx_tgl,
    output logic        tok_req,
    output logic [2:0]  tok_kind,
    output logic [3:0]  tok_ep,
    output logic        tok_tgl,
    output logic        rx_tgl_err,
    output logic [7:0]  cmd_rd,
    output logic        cmp_flag,
    output logic        cmp_irq
);
    tok_cmd_t cmd_d, cmd_q;
    logic     busy, ready, done;

    assign busy = (cmd_q.sel != TK_NONE);
    assign done = tok_req & eng_done & ~soft_rst;

    always_comb begin
        cmd_d = cmd_q;
        if (soft_rst) begin
            cmd_d = '0;
        end else if (busy) begin
            if (done) cmd_d.sel = TK_NONE;
        end else if (wr_en) begin
            cmd_d.tgl = wr_data[7];
            cmd_d.ep  = wr_data[EP_W-1:0];
            if (host_mode && link_up && kind_ok(wr_data[6:4]))
                cmd_d.sel = tok_kind_e'(wr_data[6:4]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    usb_tok_holdoff #(.HOLD(HOLD_BITS)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (done),
        .bit_en (bit_en),
        .ready  (ready)
    );

    usb_tok_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (done),
        .clr   (irq_clr),
        .en    (irq_en),
        .flag  (cmp_flag),
        .irq   (cmp_irq)
    );

    assign tok_req    = busy & ready;
    assign tok_kind   = tok_req ? cmd_q.sel : TK_NONE;
    assign tok_ep     = (cmd_q.sel == TK_SOF) ? '0 : cmd_q.ep;
    assign tok_tgl    = (cmd_q.sel == TK_SOF) ? 1'b0 : cmd_q.tgl;
    assign rx_tgl_err = rx_valid & (rx_tgl ^ cmd_q.tgl);
    assign cmd_rd     = cmd_q;

    AST_KIND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_req && eng_done && !soft_rst) |=> (cmd_rd[6:4] == 3'd0)); // R5
    AST_TGL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !soft_rst) |=> $stable(cmd_rd[7])); // R10
    AST_HOST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && !(host_mode && link_up)) |=> (cmd_rd[6:4] == 3'd0)); // R4
    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cmd_rd == 8'h00)); // R11
endmodule

// File: tb/sim_usb_tok_ctrl.sv
module sim_usb_tok_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, host_mode = 1, link_up = 1, bit_en = 0, wr_en = 0;
    logic [7:0] wr_data = 8'h00;
    logic irq_clr = 0, irq_en = 0, eng_done = 0, rx_valid = 0, rx_tgl = 0;
    logic tok_req, tok_tgl, rx_tgl_err, cmp_flag, cmp_irq;
    logic [2:0] tok_kind;
    logic [3:0] tok_ep;
    logic [7:0] cmd_rd;

    always #4 clk = ~clk;

    usb_tok_ctrl u0 (.*);

    int checks = 0, errors = 0;
    bit finished = 0;
    int m_tgl = 0, m_sel = 0, m_ep = 0, m_cnt = 0, m_flag = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_req();
        return (m_sel != 0 && m_cnt == 0) ? 1 : 0;
    endfunction

    task automatic compare_all();
        #1;
        chk("R5 tok_req", int'(tok_req), m_req());
        chk("R3 tok_kind", int'(tok_kind), m_req() ? m_sel : 0);
        chk("R7 tok_ep", int'(tok_ep), (m_sel == 4) ? 0 : m_ep);
        chk("R7 tok_tgl", int'(tok_tgl), (m_sel == 4) ? 0 : m_tgl);
        chk("R8 rx_tgl_err", int'(rx_tgl_err), (rx_valid && (int'(rx_tgl) != m_tgl)) ? 1 : 0);
        chk("R2 cmd_rd", int'(cmd_rd), m_tgl * 128 + m_sel * 16 + m_ep);
        chk("R6 cmp_flag", int'(cmp_flag), m_flag);
        chk("R6 cmp_irq", int'(cmp_irq), (m_flag != 0 && irq_en) ? 1 : 0);
    endtask

    task automatic model_update();
        int done;
        int wsel;
        done = (m_req() != 0 && eng_done && !soft_rst) ? 1 : 0;
        if (done != 0) m_cnt = 3;
        else if (bit_en && m_cnt > 0) m_cnt = m_cnt - 1;
        m_flag = ((m_flag != 0 && !irq_clr) || done != 0) ? 1 : 0;
        wsel = int'(wr_data[6:4]);
        if (soft_rst) begin
            m_tgl = 0; m_sel = 0; m_ep = 0;
        end else if (m_sel != 0) begin
            if (done != 0) m_sel = 0;
        end else if (wr_en) begin
            m_tgl = int'(wr_data[7]);
            m_ep  = int'(wr_data[3:0]);
            if (host_mode && link_up && wsel >= 1 && wsel <= 4) m_sel = wsel;
        end
    endtask

    task automatic step();
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; eng_done = 0; irq_clr = 0; bit_en = 0; soft_rst = 0; rx_valid = 0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R5 watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 cmd_rd", int'(cmd_rd), 0);
        chk("R1 tok_req", int'(tok_req), 0);
        chk("R1 cmp_flag", int'(cmp_flag), 0);
        @(negedge clk);
        rst_n = 1;
        step();

        // R2/R5: IN to endpoint 5 with DATA1
        wr_en = 1; wr_data = 8'hA5; step();
        idle(); chk("R2 byte", int'(cmd_rd), 8'hA5);
        step(); step();
        irq_en = 1; eng_done = 1; step();
        idle(); chk("R5 kind cleared", int'(cmd_rd[6:4]), 0);
        chk("R6 irq", int'(cmp_irq), 1);

        // R9: write right after completion, then count bit_en pulses
        wr_en = 1; wr_data = 8'h33; step();
        idle(); step(); step();
        chk("R9 held", int'(tok_req), 0);
        bit_en = 1; step(); step();
        chk("R9 held after two", int'(tok_req), 0);
        step();
        bit_en = 0; chk("R9 released", int'(tok_req), 1);

        // R10: write while busy is ignored, including the toggle
        wr_en = 1; wr_data = 8'hC7; step();
        wr_en = 0; chk("R10 unchanged", int'(cmd_rd), 8'h33);

        // R6: done and clear in the same cycle, set wins
        eng_done = 1; irq_clr = 1; step();
        idle(); chk("R6 set wins", int'(cmp_flag), 1);
        irq_clr = 1; step();
        idle(); chk("R6 cleared", int'(cmp_flag), 0);
        bit_en = 1; step(); step(); step(); idle();

        // R3: reserved kind
        wr_en = 1; wr_data = 8'h62; step();
        idle(); chk("R3 reserved", int'(cmd_rd[6:4]), 0);

        // R4: not host, disconnected
        host_mode = 0; wr_en = 1; wr_data = 8'h21; step();
        idle(); chk("R4 no host", int'(cmd_rd[6:4]), 0);
        host_mode = 1; link_up = 0; wr_en = 1; wr_data = 8'h11; step();
        idle(); chk("R4 no link", int'(tok_req), 0);
        link_up = 1;

        // R11: soft reset write ignored and clears
        soft_rst = 1; wr_en = 1; wr_data = 8'h9F; step();
        idle(); chk("R11 cleared", int'(cmd_rd), 0);

        // R7: SOF masks toggle and endpoint
        wr_en = 1; wr_data = 8'hCF; step();
        idle(); chk("R7 ep masked", int'(tok_ep), 0);
        chk("R7 tgl masked", int'(tok_tgl), 0);

        // R8: toggle mismatch on receive
        rx_valid = 1; rx_tgl = 0; #1 chk("R8 mismatch", int'(rx_tgl_err), 1);
        rx_valid = 0;
        eng_done = 1; step(); idle();

        // R12: done while no request
        bit_en = 0; irq_clr = 1; step(); idle();
        eng_done = 1; step(); idle();
        chk("R12 no flag", int'(cmp_flag), 0);

        // random traffic
        for (int i = 0; i < 2000; i++) begin
            wr_en     = ($urandom_range(5) == 0);
            wr_data   = 8'($urandom);
            eng_done  = ($urandom_range(2) == 0);
            irq_clr   = ($urandom_range(3) == 0);
            irq_en    = 1'($urandom);
            bit_en    = 1'($urandom);
            soft_rst  = ($urandom_range(39) == 0);
            host_mode = ($urandom_range(7) != 0);
            link_up   = ($urandom_range(7) != 0);
            rx_valid  = 1'($urandom);
            rx_tgl    = 1'($urandom);
            step();
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule